// File: doc/BRIEF.md
# Dual-Port Mailbox Doorbell

This block turns the two highest locations of a two-port shared memory into doorbells. Each port owns one mailbox word. The owner of the upper-minus-one word is port A and the owner of the top word is port B. When one port writes the other port's mailbox word, the owner's active-low interrupt output goes low. It stays low until the owner reads its own mailbox word.

The block only watches the access strobes of both ports: chip select, output enable, write strobe, address and the port's effective busy flag. It does not store the message byte, because the mailbox words remain ordinary memory locations handled by the array. A port whose busy flag is low can neither raise nor clear a doorbell.

The model is synchronous. Every port input is sampled on the rising clock edge, and each interrupt output comes from a register.

Top module: `mbox_doorbell`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, both `a_irq_n` and `b_irq_n` are high.
- R2: A port B write (`b_cs_n`=0, `b_wr_n`=0, `b_busy_n`=1) to address 0x7FFE drives `a_irq_n` low one clock after the sampling edge.
- R3: A port A write (`a_cs_n`=0, `a_wr_n`=0, `a_busy_n`=1) to address 0x7FFF drives `b_irq_n` low one clock after the sampling edge.
- R4: A port A access with `a_cs_n`=0, `a_oe_n`=0, `a_busy_n`=1 to 0x7FFE returns `a_irq_n` high one clock later, whatever the value of `a_wr_n`.
- R5: A port B access with `b_cs_n`=0, `b_oe_n`=0, `b_busy_n`=1 to 0x7FFF returns `b_irq_n` high one clock later, whatever the value of `b_wr_n`.
- R6: A set access made while the writing port's busy flag is low (0) leaves the target interrupt unchanged.
- R7: A clear access made while the owning port's busy flag is low (0) leaves its interrupt unchanged.
- R8: When a set and a clear of the same interrupt fall in the same cycle, the interrupt is low afterwards.
- R9: None of the following changes either interrupt: accesses to any other address, a port writing its own mailbox word, an access with chip select high, or a read strobe with output enable high.
- R10: With no set or clear access, each interrupt holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_wr_n | input | 1 | Port A write strobe, active low |
| a_addr | input | ADDR_W | Port A word address |
| a_busy_n | input | 1 | Port A effective busy, low blocks the port |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_wr_n | input | 1 | Port B write strobe, active low |
| b_addr | input | ADDR_W | Port B word address |
| b_busy_n | input | 1 | Port B effective busy, low blocks the port |
| a_irq_n | output | 1 | Port A doorbell interrupt, active low, always driven |
| b_irq_n | output | 1 | Port B doorbell interrupt, active low, always driven |

## Verification
Every result of this block is due exactly one clock after the rising edge that samples the access: set, clear, suppression and hold alike. There is no path longer than one register. The driver applies each access on a falling edge and queues the expected interrupt pair, tagged with the number of the rising edge that follows. The monitor compares only on a later falling edge, after that rising edge has passed. As a result, each queued expectation meets the register value it predicts and never the value from before.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   localparam int unsigned NUM_SIDES = 2;

   // Strobes of one port, all active low
   typedef struct packed {
      logic cs_n;
      logic oe_n;
      logic wr_n;
      logic busy_n;
   } port_ctl_t;

endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode #(
   parameter int unsigned        ADDR_W    = 15,
   parameter logic [ADDR_W-1:0]  POST_ADDR = '1,
   parameter logic [ADDR_W-1:0]  TAKE_ADDR = '0
) (
   input  mbox_pkg::port_ctl_t   ctl,
   input  logic [ADDR_W-1:0]     addr,
   output logic                  post_hit,
   output logic                  take_hit
);

   logic sel_ok;
   logic at_post;
   logic at_take;

   always_comb begin
      sel_ok  = !ctl.cs_n && ctl.busy_n;
      at_post = (addr == POST_ADDR);
      at_take = (addr == TAKE_ADDR);
      // doorbell ring: a write into the partner's mailbox word
      post_hit = sel_ok && !ctl.wr_n && at_post;
      // acknowledge: output enabled on own word, write strobe ignored
      take_hit = sel_ok && !ctl.oe_n && at_take;
   end

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic irq_n_o
);

   logic pending_q;
   logic pending_d;

   always_comb begin
      pending_d = pending_q;
      if (clr_i) pending_d = 1'b0;
      if (set_i) pending_d = 1'b1;   // ring beats acknowledge
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pending_q <= 1'b0;
      else        pending_q <= pending_d;
   end

   assign irq_n_o = ~pending_q;

endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell #(
   parameter int unsigned ADDR_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_cs_n,
   input  logic              a_oe_n,
   input  logic              a_wr_n,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic              a_busy_n,
   input  logic              b_cs_n,
   input  logic              b_oe_n,
   input  logic              b_wr_n,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic              b_busy_n,
   output logic              a_irq_n,
   output logic              b_irq_n
);

   import mbox_pkg::*;

   // mailbox words: side 0 owns top-1, side 1 owns top
   localparam logic [ADDR_W-1:0] BOX_B = '1;
   localparam logic [ADDR_W-1:0] BOX_A = {{(ADDR_W-1){1'b1}}, 1'b0};

   generate
      if (ADDR_W < 2 || ADDR_W > 31) begin : g_bad_width
         $error("mbox_doorbell: ADDR_W must lie in 2..31");
      end
   endgenerate

   port_ctl_t         ctl_v    [NUM_SIDES];
   logic [ADDR_W-1:0] addr_v   [NUM_SIDES];
   logic              post_v   [NUM_SIDES];
   logic              take_v   [NUM_SIDES];
   logic              irq_n_v  [NUM_SIDES];

   assign ctl_v[0]  = '{cs_n: a_cs_n, oe_n: a_oe_n, wr_n: a_wr_n, busy_n: a_busy_n};
   assign ctl_v[1]  = '{cs_n: b_cs_n, oe_n: b_oe_n, wr_n: b_wr_n, busy_n: b_busy_n};
   assign addr_v[0] = a_addr;
   assign addr_v[1] = b_addr;

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      localparam int unsigned       PEER = NUM_SIDES - 1 - s;
      localparam logic [ADDR_W-1:0] OWN  = (s == 0) ? BOX_A : BOX_B;
      localparam logic [ADDR_W-1:0] FAR  = (s == 0) ? BOX_B : BOX_A;

      mbox_port_decode #(
         .ADDR_W    (ADDR_W),
         .POST_ADDR (FAR),
         .TAKE_ADDR (OWN)
      ) u_dec (
         .ctl      (ctl_v[s]),
         .addr     (addr_v[s]),
         .post_hit (post_v[s]),
         .take_hit (take_v[s])
      );

      // flag of side s: rung by the peer, acknowledged by its owner
      mbox_flag u_flag (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_i   (post_v[PEER]),
         .clr_i   (take_v[s]),
         .irq_n_o (irq_n_v[s])
      );
   end

   assign a_irq_n = irq_n_v[0];
   assign b_irq_n = irq_n_v[1];

endmodule

// File: rtl/mbox_doorbell_chk.sv
module mbox_doorbell_chk #(
   parameter int unsigned ADDR_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              a_cs_n,
   input logic              a_oe_n,
   input logic              a_wr_n,
   input logic [ADDR_W-1:0] a_addr,
   input logic              a_busy_n,
   input logic              b_cs_n,
   input logic              b_oe_n,
   input logic              b_wr_n,
   input logic [ADDR_W-1:0] b_addr,
   input logic              b_busy_n,
   input logic              a_irq_n,
   input logic              b_irq_n
);

   localparam logic [ADDR_W-1:0] TOP_W  = '1;
   localparam logic [ADDR_W-1:0] NEXT_W = {{(ADDR_W-1){1'b1}}, 1'b0};

   logic ring_a, ring_b, ack_a, ack_b;
   assign ring_a = !b_cs_n && !b_wr_n && b_busy_n && (b_addr == NEXT_W);
   assign ring_b = !a_cs_n && !a_wr_n && a_busy_n && (a_addr == TOP_W);
   assign ack_a  = !a_cs_n && !a_oe_n && a_busy_n && (a_addr == NEXT_W);
   assign ack_b  = !b_cs_n && !b_oe_n && b_busy_n && (b_addr == TOP_W);

   // R2
   a_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ring_a |=> !a_irq_n);
   // R3
   b_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ring_b |=> !b_irq_n);
   // R4
   a_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_a && !ring_a) |=> a_irq_n);
   // R5
   b_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_b && !ring_b) |=> b_irq_n);
   // R10
   a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ring_a && !ack_a) |=> $stable(a_irq_n));
   // R10
   b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ring_b && !ack_b) |=> $stable(b_irq_n));
   // R6
   a_busy_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!b_cs_n && !b_wr_n && !b_busy_n && (b_addr == NEXT_W) && !ack_a) |=> $stable(a_irq_n));
   // R7
   b_busy_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!b_cs_n && !b_oe_n && !b_busy_n && (b_addr == TOP_W) && !ring_b) |=> $stable(b_irq_n));

endmodule

bind mbox_doorbell mbox_doorbell_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .a_cs_n(a_cs_n), .a_oe_n(a_oe_n), .a_wr_n(a_wr_n), .a_addr(a_addr), .a_busy_n(a_busy_n),
   .b_cs_n(b_cs_n), .b_oe_n(b_oe_n), .b_wr_n(b_wr_n), .b_addr(b_addr), .b_busy_n(b_busy_n),
   .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
);

// File: tb/mbox_doorbell_test.sv
`timescale 1ns/1ps
module mbox_doorbell_test;

   localparam int unsigned AW = 15;
   localparam logic [AW-1:0] BOXA = 15'h7FFE;
   localparam logic [AW-1:0] BOXB = 15'h7FFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic a_cs_n = 1'b1, a_oe_n = 1'b1, a_wr_n = 1'b1, a_busy_n = 1'b1;
   logic b_cs_n = 1'b1, b_oe_n = 1'b1, b_wr_n = 1'b1, b_busy_n = 1'b1;
   logic [AW-1:0] a_addr = '0, b_addr = '0;
   logic a_irq_n, b_irq_n;

   always #2 clk = ~clk;

   mbox_doorbell #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n),
      .a_cs_n(a_cs_n), .a_oe_n(a_oe_n), .a_wr_n(a_wr_n), .a_addr(a_addr), .a_busy_n(a_busy_n),
      .b_cs_n(b_cs_n), .b_oe_n(b_oe_n), .b_wr_n(b_wr_n), .b_addr(b_addr), .b_busy_n(b_busy_n),
      .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
   );

   typedef struct {
      int    due;
      bit    ea;
      bit    eb;
      string tag;
   } exp_t;

   exp_t sb[$];
   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   bit   pend_a = 0, pend_b = 0;   // bench model: 1 = doorbell pending

   always @(posedge clk) cyc <= cyc + 1;

   // monitor
   always begin
      @(negedge clk);
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (a_irq_n !== e.ea || b_irq_n !== e.eb) begin
            errors++;
            $display("FAIL %s: irq a/b actual %b/%b expected %b/%b",
                     e.tag, a_irq_n, b_irq_n, e.ea, e.eb);
         end
      end
   end

   task automatic direct_check(input string tag);
      checks++;
      if (a_irq_n !== 1'b1 || b_irq_n !== 1'b1) begin
         errors++;
         $display("FAIL %s: irq a/b actual %b/%b expected 1/1", tag, a_irq_n, b_irq_n);
      end
   endtask

   // driver: one access cycle on both ports
   task automatic step(input bit acs, aoe, awr, input logic [AW-1:0] aa, input bit abusy,
                       input bit bcs, boe, bwr, input logic [AW-1:0] ba, input bit bbusy,
                       input string tag);
      exp_t e;
      bit ring_a, ring_b, ack_a, ack_b;
      @(negedge clk);
      a_cs_n = acs; a_oe_n = aoe; a_wr_n = awr; a_addr = aa; a_busy_n = abusy;
      b_cs_n = bcs; b_oe_n = boe; b_wr_n = bwr; b_addr = ba; b_busy_n = bbusy;
      ring_a = !bcs && !bwr && bbusy && ba == BOXA;
      ring_b = !acs && !awr && abusy && aa == BOXB;
      ack_a  = !acs && !aoe && abusy && aa == BOXA;
      ack_b  = !bcs && !boe && bbusy && ba == BOXB;
      if (ring_a) pend_a = 1; else if (ack_a) pend_a = 0;
      if (ring_b) pend_b = 1; else if (ack_b) pend_b = 0;
      e.due = cyc + 1; e.ea = !pend_a; e.eb = !pend_b; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input string tag);
      step(1,1,1,'0,1, 1,1,1,'0,1, tag);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      direct_check("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      direct_check("R1 after release");
      idle("R10 idle");
      // B rings A
      step(1,1,1,'0,1, 0,1,0,BOXA,1, "R2 ring A");
      idle("R10 hold pending");
      step(0,0,1,BOXB,1, 1,1,1,'0,1, "R9 A reads wrong word");
      step(0,0,0,BOXA,1, 1,1,1,'0,1, "R4 A ack with write strobe low");
      step(0,1,0,BOXB,0, 1,1,1,'0,1, "R6 A ring while busy");
      step(0,1,0,BOXB,1, 1,1,1,'0,1, "R3 ring B");
      step(1,1,1,'0,1, 0,0,1,BOXB,0, "R7 B ack while busy");
      step(1,1,1,'0,1, 0,1,1,BOXB,1, "R9 B oe high");
      step(1,1,1,'0,1, 0,0,1,BOXB,1, "R5 B ack");
      step(0,1,0,BOXA,1, 1,1,1,'0,1, "R9 A writes own word");
      step(1,1,1,'0,1, 0,1,0,15'h7FFD,1, "R9 B writes other address");
      step(1,1,1,'0,1, 1,1,0,BOXA,1, "R9 B chip select high");
      step(0,0,1,BOXA,1, 0,1,0,BOXA,1, "R8 ring and ack of A together");
      step(0,0,1,BOXA,1, 1,1,1,'0,1, "R4 A ack");
      step(0,1,0,BOXB,1, 0,0,1,BOXB,1, "R8 ring and ack of B together");
      step(0,1,0,BOXB,1, 0,1,0,BOXA,1, "R2 R3 cross ring");
      step(0,0,1,BOXA,1, 0,0,0,BOXB,1, "R4 R5 both ack");
      step(1,1,1,'0,1, 0,1,0,BOXA,0, "R6 B ring while busy");
      for (int i = 0; i < 8; i++) begin
         step(0,1,0,BOXB - AW'(2 + i),1, 0,1,0,AW'(i),1, "R9 address sweep");
      end
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule